// File: doc/BRIEF.md
# Pin Test Vector Sequencer

This block runs a stored list of test vectors against a device under test that hangs off a bank of numbered pins. A format step first binds each vector column to one physical pin and says whether that column is driven into the device or observed from it. Vectors are then appended one at a time. Each vector carries one 2-bit symbol per column. A driven column's symbol can give a steady low, a steady high, a low-high-low pulse, or a forced low. An observed column's symbol gives an expected low, an expected high, or "do not compare".

After a start pulse the block walks the vectors in the order they were loaded. For each vector it applies the drive pattern and expands pulse symbols over three phases. It waits a programmable settle time, samples the observed pins and compares them against the expectations. Failing vectors are counted, and the first failure is recorded by vector index and pin. The run never stops early. A done pulse marks the end, and pass reflects a zero failure count.

Top module: `pin_vector_sequencer`

## Requirements
- R1: After reset, busy, done and every dutDrive and dutOe bit are low, failCount is zero and pass is high.
- R2: Only pins bound to driven columns (fmtDir=0) have dutOe high. Outside a run, dutDrive is all zero. During a vector, symbol 2'b01 drives its pin high for the whole vector, and symbols 2'b00 and 2'b11 drive it low for the whole vector.
- R3: Symbol 2'b10 on a driven column gives its pin a low cycle, then a high cycle, then low for the rest of the vector.
- R4: An observed column's symbol is compared against its pin: 2'b00 expects low and 2'b01 expects high. Any symbol with bit 1 set is never compared.
- R5: Each vector takes 3 + max(settleCycles,1) + 1 cycles, and the sample is taken in the last of those cycles. done rises exactly N times that count after the clock edge that accepts start.
- R6: A vector with at least one mismatch adds exactly one to failCount. firstFailVec and firstFailPin hold the index and pin of the first failing vector, taking the lowest-numbered failing column. Later vectors still run.
- R7: done is high for exactly one cycle. busy is high from the edge that accepts start through the done cycle. pass is high exactly when failCount is zero.
- R8: An accepted start clears failCount and the first-failure record. A start that arrives while busy is ignored.
- R9: fmtStart discards the format and all stored vectors. A run with no vectors gives done in the first cycle after start, with pass high.
- R10: fmtStart, fmtWe and vecWe are ignored while busy.
- R11: Vectors run in the order they were appended. Column c occupies vecData bits [2c+1:2c], and format columns are numbered in the order they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtStart | input | 1 | Clear format and vector store |
| fmtWe | input | 1 | Append one format column |
| fmtPin | input | PIN_W | Pin index for the appended column |
| fmtDir | input | 1 | 1 = observed column, 0 = driven column |
| vecWe | input | 1 | Append one vector |
| vecData | input | 2*MAX_COLS | Column symbols, column c at bits [2c+1:2c] |
| settleCycles | input | SETTLE_W | Wait cycles before sampling (0 acts as 1) |
| start | input | 1 | Begin a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | High when failCount is zero |
| failCount | output | VEC_W+1 | Number of failing vectors |
| firstFailVec | output | VEC_W | Index of the first failing vector |
| firstFailPin | output | PIN_W | Pin of the first mismatch in that vector |
| dutDrive | output | NUM_PINS | Values driven onto device pins |
| dutOe | output | NUM_PINS | Drive enables per pin |
| dutSense | input | NUM_PINS | Values observed on device pins |

## Verification
The bench keeps the defaults of 40 pins, 8 columns, 64 vectors and a 4-bit settle field. It binds six columns to three inputs and three outputs of a small modelled device: an XOR, an AND and a flip-flop that toggles on rising edges, so a missing or extra pulse phase changes a later expected value. Settle values of 0 and 2 expose the per-vector cycle count. Runs of one, eight and zero vectors reach the first-failure record, the lowest-column rule and the empty-store path.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

  // drive phase of the current vector
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LEAD = 2'd1,
    PH_HIGH = 2'd2,
    PH_TAIL = 2'd3
  } pvs_phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrRun;
    logic       advance;
    logic       cmp;
    logic       busy;
    pvs_phase_e phase;
  } pvs_strobe_t;

  // driven-column symbols
  localparam logic [1:0] SYM_LO  = 2'b00;
  localparam logic [1:0] SYM_HI  = 2'b01;
  localparam logic [1:0] SYM_CLK = 2'b10;
  localparam logic [1:0] SYM_OFF = 2'b11;

endpackage

// File: rtl/pvs_ctrl.sv
module pvs_ctrl
  import pvs_pkg::*;
#(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                lastVec,
  input  logic                emptyRun,
  output pvs_strobe_t         strobe,
  output logic                busy,
  output logic                done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_TAIL, ST_SETTLE, ST_CMP, ST_FINISH
  } state_e;

  state_e              state;
  logic [SETTLE_W-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (start) state <= emptyRun ? ST_FINISH : ST_LEAD;
        ST_LEAD:   state <= ST_HIGH;
        ST_HIGH:   state <= ST_TAIL;
        ST_TAIL: begin
          state     <= ST_SETTLE;
          settleCnt <= (settleCycles == '0) ? SETTLE_W'(1) : settleCycles;
        end
        ST_SETTLE: begin
          if (settleCnt == SETTLE_W'(1)) state <= ST_CMP;
          else settleCnt <= settleCnt - SETTLE_W'(1);
        end
        ST_CMP:    state <= lastVec ? ST_FINISH : ST_LEAD;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy = (state != ST_IDLE);
    done = (state == ST_FINISH);
    strobe.clrRun  = (state == ST_IDLE) && start;
    strobe.cmp     = (state == ST_CMP);
    strobe.advance = (state == ST_CMP) && !lastVec;
    strobe.busy    = busy;
    case (state)
      ST_LEAD:                    strobe.phase = PH_LEAD;
      ST_HIGH:                    strobe.phase = PH_HIGH;
      ST_TAIL, ST_SETTLE, ST_CMP: strobe.phase = PH_TAIL;
      default:                    strobe.phase = PH_OFF;
    endcase
  end

  // R7: end-of-run pulse lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: a run in progress is not cut short by a new start
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/pvs_datapath.sv
module pvs_datapath
  import pvs_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int MAX_COLS = 8,
  parameter int MAX_VECS = 64,
  localparam int PIN_W  = $clog2(NUM_PINS),
  localparam int COL_W  = $clog2(MAX_COLS),
  localparam int VEC_W  = $clog2(MAX_VECS),
  localparam int DATA_W = 2 * MAX_COLS
) (
  input  logic                clk,
  input  logic                rstN,
  input  pvs_strobe_t         strobe,
  input  logic                fmtStart,
  input  logic                fmtWe,
  input  logic [PIN_W-1:0]    fmtPin,
  input  logic                fmtDir,
  input  logic                vecWe,
  input  logic [DATA_W-1:0]   vecData,
  input  logic [NUM_PINS-1:0] dutSense,
  output logic [NUM_PINS-1:0] dutDrive,
  output logic [NUM_PINS-1:0] dutOe,
  output logic                lastVec,
  output logic                emptyRun,
  output logic [VEC_W:0]      failCount,
  output logic [VEC_W-1:0]    firstFailVec,
  output logic [PIN_W-1:0]    firstFailPin
);

  localparam logic [COL_W:0] COL_LIMIT = (COL_W+1)'(MAX_COLS);
  localparam logic [VEC_W:0] VEC_LIMIT = (VEC_W+1)'(MAX_VECS);

  logic [PIN_W-1:0]  pinTab [MAX_COLS];
  logic [MAX_COLS-1:0] isObs;
  logic [COL_W:0]    colCount;
  logic [DATA_W-1:0] vecMem [MAX_VECS];
  logic [VEC_W:0]    vecCount;
  logic [VEC_W-1:0]  curIdx;
  logic [DATA_W-1:0] curVec;
  logic [MAX_COLS-1:0] colActive;
  logic              colWrEn, vecWrEn;
  logic              anyMis;
  logic [PIN_W-1:0]  misPin;

  assign colWrEn = !strobe.busy && !fmtStart && fmtWe && (colCount < COL_LIMIT);
  assign vecWrEn = !strobe.busy && !fmtStart && vecWe && (vecCount < VEC_LIMIT);

  // store pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCount <= '0;
      vecCount <= '0;
    end else if (!strobe.busy && fmtStart) begin
      colCount <= '0;
      vecCount <= '0;
    end else begin
      if (colWrEn) colCount <= colCount + (COL_W+1)'(1);
      if (vecWrEn) vecCount <= vecCount + (VEC_W+1)'(1);
    end
  end

  // store contents
  always_ff @(posedge clk) begin
    if (colWrEn) begin
      pinTab[colCount[COL_W-1:0]] <= fmtPin;
      isObs[colCount[COL_W-1:0]]  <= fmtDir;
    end
    if (vecWrEn) vecMem[vecCount[VEC_W-1:0]] <= vecData;
  end

  for (genvar g = 0; g < MAX_COLS; g++) begin : g_col
    assign colActive[g] = ((COL_W+1)'(g) < colCount);
  end

  // vector pointer
  always_ff @(posedge clk) begin
    if (!rstN)               curIdx <= '0;
    else if (strobe.clrRun)  curIdx <= '0;
    else if (strobe.advance) curIdx <= curIdx + VEC_W'(1);
  end

  assign curVec   = vecMem[curIdx];
  assign lastVec  = ({1'b0, curIdx} + (VEC_W+1)'(1)) == vecCount;
  assign emptyRun = (vecCount == '0);

  // pin drive
  always_comb begin
    logic [1:0] sym;
    dutDrive = '0;
    dutOe    = '0;
    for (int c = 0; c < MAX_COLS; c++) begin
      sym = curVec[2*c +: 2];
      if (colActive[c] && !isObs[c] && (int'(pinTab[c]) < NUM_PINS)) begin
        dutOe[pinTab[c]] = 1'b1;
        if (strobe.phase != PH_OFF &&
            (sym == SYM_HI || (sym == SYM_CLK && strobe.phase == PH_HIGH)))
          dutDrive[pinTab[c]] = 1'b1;
      end
    end
  end

  // response compare, lowest column wins
  always_comb begin
    anyMis = 1'b0;
    misPin = '0;
    for (int c = MAX_COLS - 1; c >= 0; c--) begin
      if (colActive[c] && isObs[c] && !curVec[2*c+1] &&
          (int'(pinTab[c]) < NUM_PINS) &&
          (dutSense[pinTab[c]] != curVec[2*c])) begin
        anyMis = 1'b1;
        misPin = pinTab[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrRun) begin
      failCount    <= '0;
      firstFailVec <= '0;
      firstFailPin <= '0;
    end else if (strobe.cmp && anyMis) begin
      failCount <= failCount + (VEC_W+1)'(1);
      if (failCount == '0) begin
        firstFailVec <= curIdx;
        firstFailPin <= misPin;
      end
    end
  end

  // R10: store frozen during a run
  assert_store_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busy |=> ($stable(vecCount) && $stable(colCount)));

  // R6: count moves only on a compare or a new run
  assert_count_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cmp && !strobe.clrRun) |=> $stable(failCount));

  // R6: first-failure record held once set
  assert_first_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (failCount != '0 && !strobe.clrRun) |=> ($stable(firstFailVec) && $stable(firstFailPin)));

  // R2: pins quiet outside a run
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.busy |-> (dutDrive == '0));

endmodule

// File: rtl/pin_vector_sequencer.sv
module pin_vector_sequencer
  import pvs_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int MAX_COLS = 8,
  parameter int MAX_VECS = 64,
  parameter int SETTLE_W = 4,
  localparam int PIN_W = $clog2(NUM_PINS),
  localparam int VEC_W = $clog2(MAX_VECS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fmtStart,
  input  logic                  fmtWe,
  input  logic [PIN_W-1:0]      fmtPin,
  input  logic                  fmtDir,
  input  logic                  vecWe,
  input  logic [2*MAX_COLS-1:0] vecData,
  input  logic [SETTLE_W-1:0]   settleCycles,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic                  pass,
  output logic [VEC_W:0]        failCount,
  output logic [VEC_W-1:0]      firstFailVec,
  output logic [PIN_W-1:0]      firstFailPin,
  output logic [NUM_PINS-1:0]   dutDrive,
  output logic [NUM_PINS-1:0]   dutOe,
  input  logic [NUM_PINS-1:0]   dutSense
);

  pvs_strobe_t strobe;
  logic        lastVec, emptyRun;

  pvs_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .lastVec(lastVec), .emptyRun(emptyRun),
    .strobe(strobe), .busy(busy), .done(done)
  );

  pvs_datapath #(.NUM_PINS(NUM_PINS), .MAX_COLS(MAX_COLS), .MAX_VECS(MAX_VECS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fmtStart(fmtStart), .fmtWe(fmtWe), .fmtPin(fmtPin), .fmtDir(fmtDir),
    .vecWe(vecWe), .vecData(vecData), .dutSense(dutSense),
    .dutDrive(dutDrive), .dutOe(dutOe), .lastVec(lastVec), .emptyRun(emptyRun),
    .failCount(failCount), .firstFailVec(firstFailVec), .firstFailPin(firstFailPin)
  );

  assign pass = (failCount == '0);

endmodule

// File: tb/pin_vector_sequencer_bench.sv
module pin_vector_sequencer_bench;
  localparam int NP = 40, MC = 8, MV = 64, SW = 4;
  localparam logic [1:0] I0 = 2'b00, I1 = 2'b01, IC = 2'b10, IX = 2'b11;
  localparam logic [1:0] OL = 2'b00, OH = 2'b01, OX = 2'b10;
  // columns: a(pin2) b(pin3) k(pin4) driven; x(pin5) n(pin6) q(pin7) observed
  localparam logic [15:0] VEC_TAB [8] = '{
    {4'b0, OL, OL, OL, IX, I0, I0},
    {4'b0, OH, OL, OH, IC, I0, I1},
    {4'b0, OH, OH, OL, I0, I1, I1},
    {4'b0, OL, OL, OH, IC, I1, I0},
    {4'b0, OL, OH, OH, IX, I1, I1},
    {4'b0, OH, OH, OX, IC, I0, I0},
    {4'b0, OH, OL, OH, I0, I1, IX},
    {4'b0, OL, OL, OH, I1, I0, I1}
  };
  localparam logic [7:0] EXP_FAIL = 8'b0011_0000;
  localparam int EXP_PIN [8] = '{0, 0, 0, 0, 5, 6, 0, 0};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, fmtStart, fmtWe, fmtDir, vecWe, start;
  logic [5:0] fmtPin;
  logic [15:0] vecData;
  logic [SW-1:0] settleCycles;
  logic busy, done, pass;
  logic [6:0] failCount;
  logic [5:0] firstFailVec, firstFailPin;
  logic [NP-1:0] dutDrive, dutOe, dutSense;

  pin_vector_sequencer #(.NUM_PINS(NP), .MAX_COLS(MC), .MAX_VECS(MV), .SETTLE_W(SW)) u_pin_vector_sequencer (
    .clk(clk), .rstN(rstN), .fmtStart(fmtStart), .fmtWe(fmtWe), .fmtPin(fmtPin),
    .fmtDir(fmtDir), .vecWe(vecWe), .vecData(vecData), .settleCycles(settleCycles),
    .start(start), .busy(busy), .done(done), .pass(pass), .failCount(failCount),
    .firstFailVec(firstFailVec), .firstFailPin(firstFailPin),
    .dutDrive(dutDrive), .dutOe(dutOe), .dutSense(dutSense)
  );

  // modelled device: xor, and, rising-edge toggle
  logic qTog, prevK;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qTog <= 1'b0; prevK <= 1'b0;
    end else begin
      prevK <= dutDrive[4];
      if (dutDrive[4] && !prevK) qTog <= ~qTog;
    end
  end
  always_comb begin
    dutSense    = '0;
    dutSense[5] = dutDrive[2] ^ dutDrive[3];
    dutSense[6] = dutDrive[2] & dutDrive[3];
    dutSense[7] = qTog;
  end

  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic addCol(input int pin, input bit dir);
    @(negedge clk); fmtWe = 1'b1; fmtPin = pin[5:0]; fmtDir = dir;
    @(negedge clk); fmtWe = 1'b0;
  endtask

  task automatic stdFormat();
    @(negedge clk); fmtStart = 1'b1;
    @(negedge clk); fmtStart = 1'b0;
    addCol(2, 0); addCol(3, 0); addCol(4, 0);
    addCol(5, 1); addCol(6, 1); addCol(7, 1);
  endtask

  task automatic addVec(input logic [15:0] d);
    @(negedge clk); vecWe = 1'b1; vecData = d;
    @(negedge clk); vecWe = 1'b0;
  endtask

  task automatic runMeasure(input bit disturb, output int cyc);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0; cyc = 0;
    while (!done && cyc < 2000) begin
      if (disturb && cyc == 5) begin
        start = 1'b1; fmtStart = 1'b1; vecWe = 1'b1; fmtWe = 1'b1; vecData = '0;
      end else begin
        start = 1'b0; fmtStart = 1'b0; vecWe = 1'b0; fmtWe = 1'b0;
      end
      @(posedge clk); #1; cyc++;
    end
    start = 1'b0; fmtStart = 1'b0; vecWe = 1'b0; fmtWe = 1'b0;
    @(posedge clk); #1;
    chk("R7 done one cycle", int'(done), 0);
    chk("R7 busy low after done", int'(busy), 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int cyc;
    rstN = 1'b0; fmtStart = 0; fmtWe = 0; fmtDir = 0; vecWe = 0; start = 0;
    fmtPin = '0; vecData = '0; settleCycles = 4'd2;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 pass", int'(pass), 1);
    chk("R1 failCount", int'(failCount), 0);
    chk("R1 dutDrive", int'(dutDrive != '0), 0);
    chk("R1 dutOe", int'(dutOe != '0), 0);

    // table walk: one vector per run (R4, R5, R6)
    for (int i = 0; i < 8; i++) begin
      stdFormat();
      addVec(VEC_TAB[i]);
      runMeasure(0, cyc);
      chk("R5 single vector length", cyc, 6);
      chk("R4 compare result", int'(failCount), int'(EXP_FAIL[i]));
      chk("R7 pass flag", int'(pass), int'(!EXP_FAIL[i]));
      if (EXP_FAIL[i]) chk("R6 failing pin", int'(firstFailPin), EXP_PIN[i]);
    end

    // full run in load order (R11)
    stdFormat();
    for (int i = 0; i < 8; i++) addVec(VEC_TAB[i]);
    runMeasure(0, cyc);
    chk("R5 run length settle 2", cyc, 48);
    chk("R6 fail count", int'(failCount), 2);
    chk("R11 first failing vector", int'(firstFailVec), 4);
    chk("R6 first failing pin", int'(firstFailPin), 5);
    chk("R7 pass low", int'(pass), 0);

    // loads and start while busy ignored, counters cleared (R8, R10)
    runMeasure(1, cyc);
    chk("R10 run length unchanged", cyc, 48);
    chk("R8 count cleared on start", int'(failCount), 2);
    chk("R8 first vector", int'(firstFailVec), 4);

    // settle 0 acts as 1 (R5)
    settleCycles = 4'd0;
    runMeasure(0, cyc);
    chk("R5 run length settle 0", cyc, 40);
    chk("R5 results settle 0", int'(failCount), 2);
    settleCycles = 4'd2;

    // two wrong columns: lowest column reported (R6)
    stdFormat();
    addVec({4'b0, OL, OL, OH, IX, I1, I1});
    runMeasure(0, cyc);
    chk("R6 one per vector", int'(failCount), 1);
    chk("R6 lowest column pin", int'(firstFailPin), 5);

    // fmtStart discards store; empty run (R9, R8)
    @(negedge clk); fmtStart = 1'b1;
    @(negedge clk); fmtStart = 1'b0;
    runMeasure(0, cyc);
    chk("R9 empty run immediate", cyc, 0);
    chk("R9 empty pass", int'(pass), 1);
    chk("R8 cleared count", int'(failCount), 0);

    // pulse waveform and steady levels (R2, R3)
    stdFormat();
    addVec({4'b0, OX, OX, OX, IC, IX, I1});
    chk("R2 oe driven pin", int'(dutOe[2]), 1);
    chk("R2 oe pulse pin", int'(dutOe[4]), 1);
    chk("R2 oe observed pin", int'(dutOe[5]), 0);
    chk("R2 oe unmapped pin", int'(dutOe[0]), 0);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    for (int j = 0; j < 6; j++) begin
      chk("R3 pulse pin phase", int'(dutDrive[4]), (j == 1) ? 1 : 0);
      chk("R2 high symbol", int'(dutDrive[2]), 1);
      chk("R2 forced low symbol", int'(dutDrive[3]), 0);
      @(posedge clk); #1;
    end
    chk("R7 done after vector", int'(done), 1);
    chk("R2 drive released", int'(dutDrive != '0), 0);
    chk("R4 all ignored passes", int'(pass), 1);
    @(posedge clk); #1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule